// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function I/O controller. It sits on a byte-wide I/O bus with a single-cycle write strobe and a read strobe, and it answers at two addresses. The first address is an index port and the second is a data port. It starts out locked. In that state it only watches index-port writes for an unlock key, which is two back-to-back writes of 0x87.

Once unlocked, the host writes a register number to the index port. It then reads or writes that register through the data port. Registers below 0x30 are global. Register 0x07 selects a logical device. Registers 0x20 and 0x21 return a fixed chip identifier. Registers from 0x30 up are kept separately for each logical device. Bit 0 of register 0x30 in each device bank is exported as that device's enable line.

Writing 0x02 to register 0x02 locks the port again.

Top module: `sio_cfg_port`

## Requirements
- R1: Only address 0x2E (index port) and 0x2F (data port) are decoded. For any other address, writes have no effect, `io_rdata_oe` stays 0 and `io_rdata` reads 0x00. For a read of either port, `io_rdata_oe` is 1 in the same cycle as `io_rd`, and the data is combinational.
- R2: The port unlocks after two consecutive index-port writes of 0x87. Any other index-port byte written while locked clears the key progress. Data-port accesses do not affect the key progress. While locked, reads of either port return 0xFF.
- R3: While locked, data-port writes are ignored, and index-port writes do not change the index register.
- R4: While unlocked, an index-port write loads the index register, and an index-port read returns it. A data-port write goes to the register the index names, and a data-port read returns that register.
- R5: A data-port write of 0x02 while the index is 0x02 locks the port. Any other value written to register 0x02 is discarded. Register 0x02 always reads 0x00.
- R6: Register 0x07 holds the logical device number in bits 2:0. Its upper bits read as 0.
- R7: Register 0x20 reads 0x87 and register 0x21 reads 0x11. Writes to them have no effect.
- R8: Registers 0x00 to 0x2F, other than 0x02, 0x07, 0x20 and 0x21, are read/write storage shared by all devices. Registers 0x30 to 0xFF are read/write storage held separately for each of devices 0 to 7, and the current value of register 0x07 selects the bank.
- R9: `dev_enable[n]` equals bit 0 of register 0x30 in bank n.
- R10: After reset the port is locked, the index is 0, and every writable register is 0. This includes the device number and `dev_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not driven |
| io_rdata_oe | output | 1 | High when this block supplies read data |
| dev_enable | output | 8 | Per-device activate bits |

## Verification
Directed sequences cover several unlock patterns:
- An interrupted key (0x87, 0x00, 0x87), which must stay locked. This separates a counter that restarts on a wrong byte from one that only counts 0x87 writes.
- A clean key.
- Exit attempts with a wrong value and with the right value, which separate a real exit from any write to register 0x02.

Bank tests program the same register differently under two device numbers, then read a global register under both numbers. This tells banked storage apart from shared storage. The enable lines are checked against both banks.

A long seeded random mix of key bytes, index choices, data writes, reads and foreign addresses is then compared against a bench model. The mix is biased toward the special registers, so that state changes in the lock, the device number and the exit reach every kind of register.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [7:0] REG_EXIT  = 8'h02;
   localparam logic [7:0] REG_LDN   = 8'h07;
   localparam logic [7:0] REG_ID_HI = 8'h20;
   localparam logic [7:0] REG_ID_LO = 8'h21;
   localparam logic [7:0] EXIT_CODE = 8'h02;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_INDEX = 2'd1,
      SEL_DATA  = 2'd2
   } port_sel_e;
endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
   import sio_cfg_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h002F
) (
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel
);
   initial begin
      assert (IDX_ADDR != DAT_ADDR) else $error("index and data ports must differ");
   end

   always_comb begin
      if (addr == IDX_ADDR)      sel = SEL_INDEX;
      else if (addr == DAT_ADDR) sel = SEL_DATA;
      else                       sel = SEL_NONE;
   end
endmodule

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock #(
   parameter int         KEY_LEN = 2,
   parameter logic [7:0] KEY_VAL = 8'h87
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       exit_cmd,
   output logic       unlocked
);
   localparam int CNT_W = $clog2(KEY_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_LEN - 1);

   initial begin
      assert (KEY_LEN >= 1) else $error("key must have at least one byte");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         open_q <= 1'b0;
      end else if (open_q) begin
         cnt_q <= '0;
         if (exit_cmd) open_q <= 1'b0;
      end else if (key_wr) begin
         if (key_byte == KEY_VAL) begin
            if (cnt_q == CNT_LAST) begin
               open_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign unlocked = open_q;

   // R2
   unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(key_wr && key_byte == KEY_VAL));

   // R2
   key_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

   // R5
   exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && exit_cmd) |=> !open_q);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
   import sio_cfg_pkg::*;
#(
   parameter int          NUM_DEV   = 8,
   parameter logic [7:0]  BANK_BASE = 8'h30,
   parameter logic [15:0] CHIP_ID   = 16'h8711
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unlocked,
   input  logic               idx_wr,
   input  logic               dat_wr,
   input  logic [7:0]         wdata,
   output logic [7:0]         index_q,
   output logic [7:0]         data_rd,
   output logic               exit_cmd,
   output logic [NUM_DEV-1:0] dev_enable
);
   localparam int LDN_W      = $clog2(NUM_DEV);
   localparam int GLOB_DEPTH = int'(BANK_BASE);
   localparam int GIDX_W     = $clog2(GLOB_DEPTH);
   localparam int BANK_DEPTH = 256 - int'(BANK_BASE);
   localparam int BOFF_W     = $clog2(BANK_DEPTH);

   initial begin
      assert (NUM_DEV >= 2 && (1 << LDN_W) == NUM_DEV && NUM_DEV <= 256)
         else $error("NUM_DEV must be a power of two from 2 to 256");
      assert (BANK_BASE > REG_ID_LO) else $error("banked space must lie above the id registers");
   end

   logic [7:0]       glob_q [GLOB_DEPTH];
   logic [LDN_W-1:0] ldn_q;
   logic [7:0]       bank_rd [NUM_DEV];
   logic [7:0]       bank_off;
   logic             in_bank;
   logic             wr_ok;

   assign wr_ok    = unlocked && dat_wr;
   assign in_bank  = (index_q >= BANK_BASE);
   assign bank_off = index_q - BANK_BASE;
   assign exit_cmd = wr_ok && (index_q == REG_EXIT) && (wdata == EXIT_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n)                  index_q <= '0;
      else if (unlocked && idx_wr) index_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldn_q <= '0;
         for (int i = 0; i < GLOB_DEPTH; i++) glob_q[i] <= '0;
      end else if (wr_ok && !in_bank) begin
         case (index_q)
            REG_EXIT, REG_ID_HI, REG_ID_LO: ;
            REG_LDN: ldn_q <= wdata[LDN_W-1:0];
            default: glob_q[index_q[GIDX_W-1:0]] <= wdata;
         endcase
      end
   end

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      logic [7:0] mem_q [BANK_DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < BANK_DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_ok && in_bank && ldn_q == LDN_W'(d)) begin
            mem_q[bank_off[BOFF_W-1:0]] <= wdata;
         end
      end

      assign bank_rd[d]    = mem_q[bank_off[BOFF_W-1:0]];
      assign dev_enable[d] = mem_q[0][0];
   end

   always_comb begin
      if (in_bank) begin
         data_rd = bank_rd[ldn_q];
      end else begin
         case (index_q)
            REG_EXIT:  data_rd = 8'h00;
            REG_LDN:   data_rd = {{(8-LDN_W){1'b0}}, ldn_q};
            REG_ID_HI: data_rd = CHIP_ID[15:8];
            REG_ID_LO: data_rd = CHIP_ID[7:0];
            default:   data_rd = glob_q[index_q[GIDX_W-1:0]];
         endcase
      end
   end

   // R3
   locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && (dat_wr || idx_wr)) |=> ($stable(ldn_q) && $stable(dev_enable) && $stable(index_q)));

   // R6
   ldn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && index_q == REG_LDN) |=> (ldn_q == $past(wdata[LDN_W-1:0])));

   // R9
   enable_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_enable) |-> $past(wr_ok && index_q == BANK_BASE));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h002E,
   parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h002F,
   parameter int              KEY_LEN   = 2,
   parameter logic [7:0]      KEY_VAL   = 8'h87,
   parameter int              NUM_DEV   = 8,
   parameter logic [7:0]      BANK_BASE = 8'h30,
   parameter logic [15:0]     CHIP_ID   = 16'h8711
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic               io_rdata_oe,
   output logic [NUM_DEV-1:0] dev_enable
);
   port_sel_e  sel;
   logic       idx_wr, dat_wr, unlocked, exit_cmd;
   logic [7:0] index_q, data_rd;

   sio_cfg_decode #(.ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)) i_decode (
      .addr(io_addr), .sel(sel)
   );

   assign idx_wr = io_wr && (sel == SEL_INDEX);
   assign dat_wr = io_wr && (sel == SEL_DATA);

   sio_cfg_lock #(.KEY_LEN(KEY_LEN), .KEY_VAL(KEY_VAL)) i_lock (
      .clk(clk), .rst_n(rst_n), .key_wr(idx_wr), .key_byte(io_wdata),
      .exit_cmd(exit_cmd), .unlocked(unlocked)
   );

   sio_cfg_regs #(.NUM_DEV(NUM_DEV), .BANK_BASE(BANK_BASE), .CHIP_ID(CHIP_ID)) i_regs (
      .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr), .dat_wr(dat_wr),
      .wdata(io_wdata), .index_q(index_q), .data_rd(data_rd), .exit_cmd(exit_cmd),
      .dev_enable(dev_enable)
   );

   always_comb begin
      io_rdata_oe = io_rd && (sel != SEL_NONE);
      if (!io_rdata_oe)          io_rdata = 8'h00;
      else if (!unlocked)        io_rdata = 8'hFF;
      else if (sel == SEL_INDEX) io_rdata = index_q;
      else                       io_rdata = data_rd;
   end

   // R1
   foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != IDX_ADDR && io_addr != DAT_ADDR) |-> (!io_rdata_oe && io_rdata == 8'h00));

   // R2
   locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rdata_oe && !unlocked) |-> (io_rdata == 8'hFF));
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
   localparam logic [15:0] IDX = 16'h002E;
   localparam logic [15:0] DAT = 16'h002F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rdata_oe;
   logic [7:0]  dev_enable;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   bit         m_open;
   int         m_cnt;
   logic [7:0] m_idx;
   logic [2:0] m_ldn;
   logic [7:0] m_glob [48];
   logic [7:0] m_bank [8][208];

   sio_cfg_port i_sio_cfg_port (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
      .dev_enable(dev_enable)
   );

   always #4 clk = ~clk;

   task automatic model_reset();
      m_open = 0; m_cnt = 0; m_idx = '0; m_ldn = '0;
      for (int i = 0; i < 48; i++) m_glob[i] = '0;
      for (int d = 0; d < 8; d++) for (int i = 0; i < 208; i++) m_bank[d][i] = '0;
   endtask

   task automatic model_write(input logic [15:0] a, input logic [7:0] v);
      if (a == IDX) begin
         if (!m_open) begin
            if (v == 8'h87) begin
               if (m_cnt == 1) begin m_open = 1; m_cnt = 0; end
               else m_cnt = m_cnt + 1;
            end else m_cnt = 0;
         end else m_idx = v;
      end else if (a == DAT && m_open) begin
         if (m_idx == 8'h02) begin if (v == 8'h02) m_open = 0; end
         else if (m_idx == 8'h07) m_ldn = v[2:0];
         else if (m_idx == 8'h20 || m_idx == 8'h21) begin end
         else if (m_idx < 8'h30) m_glob[m_idx] = v;
         else m_bank[m_ldn][m_idx - 8'h30] = v;
      end
   endtask

   function automatic logic [7:0] model_data();
      if (m_idx >= 8'h30) return m_bank[m_ldn][m_idx - 8'h30];
      case (m_idx)
         8'h02: return 8'h00;
         8'h07: return {5'b0, m_ldn};
         8'h20: return 8'h87;
         8'h21: return 8'h11;
         default: return m_glob[m_idx];
      endcase
   endfunction

   function automatic logic [7:0] model_en();
      logic [7:0] e;
      for (int d = 0; d < 8; d++) e[d] = m_bank[d][0][0];
      return e;
   endfunction

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_wdata = v; io_wr = 1'b1; io_rd = 1'b0;
      @(negedge clk);
      io_wr = 1'b0;
      model_write(a, v);
   endtask

   task automatic do_read(input logic [15:0] a, input string tag);
      logic [8:0] exp;
      @(negedge clk);
      io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
      #1;
      if (a != IDX && a != DAT) exp = {1'b0, 8'h00};
      else if (!m_open)         exp = {1'b1, 8'hFF};
      else if (a == IDX)        exp = {1'b1, m_idx};
      else                      exp = {1'b1, model_data()};
      check(tag, {io_rdata_oe, io_rdata}, exp);
      check({tag, " enable"}, {1'b0, dev_enable}, {1'b0, model_en()});
      io_rd = 1'b0;
   endtask

   task automatic unlock();
      do_write(IDX, 8'h87);
      do_write(IDX, 8'h87);
   endtask

   task automatic sel_reg(input logic [7:0] r);
      do_write(IDX, r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset state: locked, no enables
      do_read(DAT, "R10 locked after reset");
      do_read(IDX, "R10 index port locked");
      check("R10 enables zero", {1'b0, dev_enable}, 9'h000);

      // R3 locked writes ignored
      do_write(DAT, 8'h5A);
      do_write(IDX, 8'h10);
      do_write(IDX, 8'h87);
      do_read(DAT, "R2 one key byte still locked");
      // R2 interrupted key stays locked
      do_write(IDX, 8'h00);
      do_write(IDX, 8'h87);
      do_read(DAT, "R2 interrupted key locked");
      do_write(IDX, 8'h87);
      do_read(IDX, "R3 R10 index zero after unlock");
      do_read(DAT, "R3 R10 reg0 zero");

      // R7 chip id
      sel_reg(8'h20); do_read(DAT, "R7 id high");
      do_write(DAT, 8'h00); do_read(DAT, "R7 id high read-only");
      sel_reg(8'h21); do_read(DAT, "R7 id low");

      // R6 device number mask
      sel_reg(8'h07); do_write(DAT, 8'hFD); do_read(DAT, "R6 ldn masked");

      // R8 R9 banks
      do_write(DAT, 8'h01);
      sel_reg(8'h30); do_write(DAT, 8'h01);
      sel_reg(8'h45); do_write(DAT, 8'hA1);
      sel_reg(8'h25); do_write(DAT, 8'h3C);
      sel_reg(8'h07); do_write(DAT, 8'h02);
      sel_reg(8'h30); do_read(DAT, "R9 bank2 activate clear");
      check("R9 only device 1 enabled", {1'b0, dev_enable}, 9'h002);
      sel_reg(8'h45); do_read(DAT, "R8 bank2 separate");
      do_write(DAT, 8'hB2);
      sel_reg(8'h25); do_read(DAT, "R8 global shared");
      sel_reg(8'hFF); do_write(DAT, 8'h77); do_read(DAT, "R8 top register");
      sel_reg(8'h07); do_write(DAT, 8'h01);
      sel_reg(8'h45); do_read(DAT, "R8 bank1 kept");

      // R1 foreign addresses
      do_write(16'h002D, 8'h02);
      do_write(16'h012F, 8'h99);
      do_read(16'h002D, "R1 foreign read quiet");
      do_read(16'h0000, "R1 foreign read quiet zero addr");
      do_read(DAT, "R1 state untouched");

      // R5 exit
      sel_reg(8'h02); do_write(DAT, 8'h05);
      do_read(DAT, "R5 wrong exit value reg reads zero");
      do_read(IDX, "R5 still unlocked");
      do_write(DAT, 8'h02);
      do_read(DAT, "R5 exit locks");
      do_read(IDX, "R5 index port locked");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r;
         logic [7:0] v;
         r = $urandom_range(0, 99);
         v = 8'($urandom);
         if (r < 18) do_write(IDX, 8'h87);
         else if (r < 36) begin
            case ($urandom_range(0, 6))
               0: v = 8'h02; 1: v = 8'h07; 2: v = 8'h20; 3: v = 8'h30;
               4: v = 8'($urandom_range(0, 47)); default: v = 8'($urandom_range(48, 255));
            endcase
            do_write(IDX, v);
         end else if (r < 60) begin
            if ($urandom_range(0, 3) == 0) v = 8'h02;
            do_write(DAT, v);
         end else if (r < 72) do_read(IDX, "R2 R4 random index read");
         else if (r < 92) do_read(DAT, "R4 R8 random data read");
         else if (r < 96) do_write(16'($urandom_range(0, 16'h2D)), v);
         else do_read(16'($urandom_range(16'h30, 16'hFFFF)), "R1 random foreign read");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule